// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one management transaction on a two-wire PHY management bus for each request it takes. It has a read/write select, a 5-bit PHY address, a 5-bit register number and 16-bit write data. When the block is idle, a one-cycle start pulse takes all of these fields in. The block then produces a complete frame on the management clock, data-out and output-enable pins and samples the data-in pin where the frame needs it. When the frame is over it raises `done` for one cycle. For a read, `rd_data` holds the 16 bits returned by the PHY.

Every bit time comes from one position-indexed table that gives both the output-enable and the data value for that bit. The management clock is low for one interval and high for an equal interval in each bit. The length of that interval, in system clock cycles, comes from a divider input that is latched at start. The pins are updated only at the start of a low interval. The data-in pin is sampled in the final system cycle of a high interval.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `mdc`, `mdo`, `mdo_en` and `rd_data` are all zero.
- R2: A `start` pulse taken while idle sets `busy` from the next cycle. `busy` stays high until the frame ends. Then `done` is high for exactly one cycle, in the same cycle in which `busy` first reads low.
- R3: Bit times 0 to 31 of every frame are driven with `mdo_en`=1 and `mdo`=1.
- R4: Bit times 32 and 33 carry 0 then 1, driven. Bit times 34 and 35 carry 1,0 when `rd_nwr`=1 (read) and 0,1 when `rd_nwr`=0 (write), driven.
- R5: Bit times 36 to 40 carry `phy_addr` bit 4 down to bit 0. Bit times 41 to 45 carry `reg_addr` bit 4 down to bit 0. All ten are driven.
- R6: A write frame has 65 bit times. Bit times 46 and 47 are released (`mdo_en`=0). Bit times 48 to 63 drive `wr_data` bit 15 down to bit 0. Bit time 64 is released.
- R7: A read frame has 64 bit times, and bit times 46 to 63 are all released. The `mdi` values seen in bit times 47 to 62 land in `rd_data` bits 15 down to 0 and are valid when `done` is high. A write frame leaves `rd_data` unchanged.
- R8: `mdo` and `mdo_en` change only while `mdc` is low. `mdi` is sampled while `mdc` is high, in the last system cycle of the high interval.
- R9: Each low interval and each high interval of `mdc` lasts max(`half_period`,1) system cycles. The value used is the one present at the accepted start, and later changes to the input do not affect the frame in progress.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The frame in progress, its bit count and its timing are unchanged.
- R11: `mdo` is 0 in every cycle in which `mdo_en` is 0.
- R12: Once a frame ends, `mdc`, `mdo_en` and `mdo` are low and stay low until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| phy_addr | input | 5 | PHY address for the frame |
| reg_addr | input | 5 | Register number for the frame |
| wr_data | input | 16 | Data for a write frame |
| half_period | input | DIV_W | System cycles per management clock half-period (0 acts as 1) |
| mdi | input | 1 | Management data input pin |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data captured by the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data output value |
| mdo_en | output | 1 | Output enable for the data pad |

## Verification
The model PHY in the bench drives random noise on `mdi` in every bit time that is not a capture slot. A design that samples one bit early or late, or in the low interval, therefore returns the wrong `rd_data`. Every bit time is recorded at the rising edge of `mdc` and compared with a frame assembled independently by the bench. This exposes a one-bit turnaround on writes, a two-bit turnaround on reads, a missing trailing clock, swapped opcodes and LSB-first fields. Two more directed cases cover a divider value of 0 and a divider changed mid-frame: a design that does not latch the divider, or does not clamp it, shows low or high intervals of the wrong length. Start pulses issued in the middle of a frame with inverted fields would corrupt the frame or stretch `busy` in a design that accepted them.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [4:0]       phy_addr,
  input  logic [4:0]       reg_addr,
  input  logic [15:0]      wr_data,
  input  logic [DIV_W-1:0] half_period,
  input  logic             mdi,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdo,
  output logic             mdo_en
);

  localparam int IDX_W     = 7;
  localparam int SYNC_LEN  = 32;
  localparam int PA_LAST   = 40;
  localparam int RA_LAST   = 45;
  localparam int WD_FIRST  = 48;
  localparam int WD_LAST   = 63;
  localparam int CAP_FIRST = 47;
  localparam int CAP_LAST  = 62;
  localparam int RD_END    = 63;
  localparam int WR_END    = 64;

  function automatic logic [1:0] slot(input logic [IDX_W-1:0] i, input logic rd,
                                      input logic [4:0] pa, input logic [4:0] ra,
                                      input logic [15:0] wd);
    logic [IDX_W-1:0] j;
    if (i < IDX_W'(SYNC_LEN)) return 2'b11;
    case (i)
      IDX_W'(32): return 2'b10;
      IDX_W'(33): return 2'b11;
      IDX_W'(34): return {1'b1, rd};
      IDX_W'(35): return {1'b1, ~rd};
      default: ;
    endcase
    if (i <= IDX_W'(PA_LAST)) begin
      j = IDX_W'(PA_LAST) - i;
      return {1'b1, pa[j[2:0]]};
    end
    if (i <= IDX_W'(RA_LAST)) begin
      j = IDX_W'(RA_LAST) - i;
      return {1'b1, ra[j[2:0]]};
    end
    if (!rd && i >= IDX_W'(WD_FIRST) && i <= IDX_W'(WD_LAST)) begin
      j = IDX_W'(WD_LAST) - i;
      return {1'b1, wd[j[3:0]]};
    end
    return 2'b00;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [DIV_W-1:0] cnt, hp_q;
  logic             phase, rd_q, oe_q, val_q;
  logic [4:0]       pa_q, ra_q;
  logic [15:0]      wd_q;

  wire              tick     = (cnt == hp_q - 1'b1);
  wire              last_bit = (idx == (rd_q ? IDX_W'(RD_END) : IDX_W'(WR_END)));
  wire              capture  = rd_q && idx >= IDX_W'(CAP_FIRST) && idx <= IDX_W'(CAP_LAST);
  wire [IDX_W-1:0]  idx_nxt  = idx + 1'b1;
  wire [1:0]        first_s  = slot('0, rd_nwr, phy_addr, reg_addr, wr_data);
  wire [1:0]        next_s   = slot(idx_nxt, rd_q, pa_q, ra_q, wd_q);

  assign mdc    = phase;
  assign mdo_en = oe_q;
  assign mdo    = oe_q & val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      idx     <= '0;
      cnt     <= '0;
      hp_q    <= DIV_W'(1);
      phase   <= 1'b0;
      rd_q    <= 1'b0;
      pa_q    <= '0;
      ra_q    <= '0;
      wd_q    <= '0;
      oe_q    <= 1'b0;
      val_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          rd_q  <= rd_nwr;
          pa_q  <= phy_addr;
          ra_q  <= reg_addr;
          wd_q  <= wr_data;
          hp_q  <= (half_period == '0) ? DIV_W'(1) : half_period;
          idx   <= '0;
          cnt   <= '0;
          phase <= 1'b0;
          oe_q  <= first_s[1];
          val_q <= first_s[0];
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (capture) rd_data <= {rd_data[14:0], mdi};
          if (last_bit) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            oe_q  <= 1'b0;
            val_q <= 1'b0;
          end else begin
            idx   <= idx_nxt;
            oe_q  <= next_s[1];
            val_q <= next_s[0];
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdo,
  input logic mdo_en
);

  assert_oe_gates_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mdo_en |-> !mdo);

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_fall_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdo_en);

  assert_pins_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdo_en) && $stable(mdo));

  assert_busy_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, rd_nwr, mdi;
  logic [4:0] phy_addr, reg_addr;
  logic [15:0] wr_data;
  logic [DIV_W-1:0] half_period;
  logic busy, done, mdc, mdo, mdo_en;
  logic [15:0] rd_data;

  mdio_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .half_period(half_period), .mdi(mdi),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en)
  );

  int n_chk = 0, n_fail = 0;
  int rises = 0, run = 0, want_h = 1, bad_low = 0, bad_high = 0, bad_oe = 0;
  logic prev_mdc = 1'b0;
  logic [1:0] seen [0:127];
  logic [15:0] phy_word = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic phy_bit(input int k);
    if (k >= 47 && k <= 62) return phy_word[62 - k];
    return 1'($urandom % 2);
  endfunction

  always @(negedge clk) begin
    if (!mdo_en && mdo) bad_oe++;
    if (mdc !== prev_mdc) begin
      if (mdc) begin
        if (rises < 128) seen[rises] = {mdo_en, mdo};
        if (rises > 0 && run != want_h) bad_low++;
        rises++;
      end else if (run != want_h) bad_high++;
      run = 1;
    end else run++;
    prev_mdc = mdc;
    if (!mdc) mdi <= phy_bit(rises);
  end

  task automatic frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int hp, input bit poke);
    logic [1:0] e [$];
    logic [15:0] old_rd;
    int cyc;
    string tag;
    e.delete();
    for (int k = 0; k < 32; k++) e.push_back(2'b11);
    e.push_back(2'b10); e.push_back(2'b11);
    if (rd) begin e.push_back(2'b11); e.push_back(2'b10); end
    else    begin e.push_back(2'b10); e.push_back(2'b11); end
    for (int k = 4; k >= 0; k--) e.push_back({1'b1, pa[k]});
    for (int k = 4; k >= 0; k--) e.push_back({1'b1, ra[k]});
    if (rd) for (int k = 0; k < 18; k++) e.push_back(2'b00);
    else begin
      e.push_back(2'b00); e.push_back(2'b00);
      for (int k = 15; k >= 0; k--) e.push_back({1'b1, wd[k]});
      e.push_back(2'b00);
    end
    @(negedge clk);
    rises = 0; run = 0; bad_low = 0; bad_high = 0; bad_oe = 0;
    want_h = (hp == 0) ? 1 : hp;
    phy_word = 16'($urandom);
    old_rd = rd_data;
    start = 1'b1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    half_period = DIV_W'(hp);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", 32'(busy), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 200 * (want_h + 1)) begin
      @(negedge clk);
      cyc++;
      if (poke && (cyc == 60 || cyc == 100)) begin
        start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
        half_period = DIV_W'(hp + 3);
      end else start = 1'b0;
    end
    chk(done === 1'b1, "R2", "done pulse seen", 32'(done), 1);
    chk(busy === 1'b0, "R2", "busy low with done", 32'(busy), 0);
    chk(!mdc && !mdo_en && !mdo, "R12", "pins idle at end", {mdc, mdo_en, mdo}, 0);
    chk(rises == e.size(), rd ? "R7" : "R6", "bit count", rises, e.size());
    for (int k = 0; k < e.size() && k < rises; k++) begin
      tag = (k < 32) ? "R3" : (k < 36) ? "R4" : (k < 46) ? "R5" : rd ? "R7" : "R6";
      chk(seen[k] === e[k], tag, $sformatf("bit %0d oe/val", k), 32'(seen[k]), 32'(e[k]));
    end
    if (rd) chk(rd_data === phy_word, "R8", "read capture (R7)", rd_data, phy_word);
    else    chk(rd_data === old_rd, "R7", "write keeps rd_data", rd_data, old_rd);
    chk(bad_low == 0 && bad_high == 0, poke ? "R10" : "R9", "half-period lengths (R9)",
        bad_low + bad_high, 0);
    chk(bad_oe == 0, "R11", "mdo low when released", bad_oe, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R2", "single done pulse", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdo_en, "R12", "idle stays quiet", {mdc, mdo_en}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b1; rd_nwr = 1'b0; phy_addr = '0; reg_addr = '0;
    wr_data = '0; half_period = DIV_W'(2); mdi = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mdc && !mdo && !mdo_en && rd_data == 0, "R1", "reset outputs",
        {busy, done, mdc, mdo, mdo_en, rd_data}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mdc && !mdo_en, "R1", "after release", {busy, mdc, mdo_en}, 0);
    frame(1'b0, 5'h1f, 5'h00, 16'hffff, 1, 1'b0);
    frame(1'b1, 5'h00, 5'h1f, 16'h0000, 1, 1'b0);
    frame(1'b0, 5'h15, 5'h0a, 16'h8001, 0, 1'b0);
    frame(1'b1, 5'h0a, 5'h15, 16'h1234, 9, 1'b0);
    frame(1'b1, 5'h03, 5'h12, 16'h5555, 2, 1'b1);
    frame(1'b0, 5'h1c, 5'h04, 16'h00ff, 3, 1'b1);
    for (int n = 0; n < 30; n++)
      frame(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom),
            1 + int'($urandom % 4), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule